// File: doc/BRIEF.md
# Li-ion Charge Cycle Controller

This block sequences a linear lithium-ion charger through its phases. It looks for a battery, pre-charges a deeply discharged cell with a small current, and then runs constant current. It moves to constant voltage at the termination level and stops once the taper current is small enough. It then watches the cell and starts again when the voltage sags. It works on digitized battery voltage (mV) and battery current (mA), plus a few status flags from the analog front end. It produces a current setpoint and a voltage setpoint for the regulation loops, which live outside this block.

A single millisecond-tick timer serves three purposes. It spaces the battery-presence probes, bounds the pre-charge phase, and bounds the combined constant-current plus constant-voltage time. Any fault stops charging and is held until the supply is removed and applied again. Two active-low indicator outputs report charging and fault.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and until the supply flag has been seen, the current target and voltage target are 0 and both indicators are high (inactive).
- R2: With the supply present, battery presence (vbat_mv >= 1000) is probed on the first cycle after the supply is seen, and after that only once every RETRY_MS ticks. A battery that appears between probes is not acted on until the next probe.
- R3: In pre-charge the current target is floor(ilim_ma*10/100) and chg_n is low. The controller moves to constant current when vbat_mv >= 2900.
- R4: The termination voltage is 4100 mV with vterm_hi low and 4200 mV with it high. It is driven on vchg_tgt_mv in every charging phase and in the complete phase. Constant current moves to constant voltage when vbat_mv >= termination voltage.
- R5: In constant voltage the current target is ilim_ma. When ibat_ma <= floor(ilim_ma*10/100) the cycle is complete: the current target is 0, chg_n is high, and the voltage target stays at the termination voltage.
- R6: From complete, the controller returns to constant current when vbat_mv < floor(termination*97/100), which is 3977 mV or 4074 mV. The combined timer restarts at that point.
- R7: The pre-charge phase faults after TRICKLE_TO_MS counted ticks. Constant current and constant voltage together fault after CHARGE_TO_MS counted ticks, and the timer is not restarted between those two phases.
- R8: A fault occurs on any of these: vbat_mv < 2100 in a charging phase, short_det, or self_fault. In fault, err_n is low, chg_n is high and the current target is 0.
- R9: A fault is held while the supply flag stays high, whatever the other inputs do. It clears only after the supply flag goes low, and a new cycle starts when the flag returns.
- R10: While hdrm_ok is low in a charging phase, the current target is 0, chg_n is high, the phase is held and the phase timer does not count.
- R11: With temp_ok low the current target is 0, but chg_n stays low. With temp_reduce high in constant current the target is floor(ilim_ma/2). Constant voltage ignores temp_reduce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| vbus_ok | input | 1 | Supply present |
| hdrm_ok | input | 1 | Supply exceeds battery by enough headroom to charge |
| vterm_hi | input | 1 | Termination select: 0 = 4100 mV, 1 = 4200 mV |
| ilim_ma | input | IW | Programmed fast-charge current limit, mA |
| temp_ok | input | 1 | Battery temperature allows charging |
| temp_reduce | input | 1 | Halve the constant-current target |
| short_det | input | 1 | Battery short detected |
| self_fault | input | 1 | Internal self-check fault |
| vbat_mv | input | VW | Battery voltage, mV |
| ibat_ma | input | IW | Battery charge current, mA |
| ichg_tgt_ma | output | IW | Current setpoint, mA |
| vchg_tgt_mv | output | VW | Voltage setpoint, mV (0 when idle or faulted) |
| chg_n | output | 1 | Charging indicator, low while charging |
| err_n | output | 1 | Fault indicator, low while faulted |

## Verification
The embedded properties assume that ms_tick, the voltage and current samples and the flags are synchronous to clk. They also assume that ilim_ma stays constant within a cycle, so the pre-charge and termination percentages never exceed the limit itself. The timeout property assumes that ticks are counted only while the phase timer is enabled, so the pre-charge count cannot pass its limit without a fault. The stimulus changes inputs only just after a clock edge, keeps ilim_ma fixed within each session, and holds ms_tick high. Timeouts are therefore cycle-exact against shortened timer parameters.

// File: rtl/chg_cycle_pkg.sv
package chg_cycle_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_DETECT,
    ST_TRICKLE,
    ST_FAST,
    ST_CV,
    ST_DONE,
    ST_FAULT
  } chg_state_e;
endpackage

// File: rtl/chg_ms_timer.sv
module chg_ms_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_nx;

  // clear wins; count saturates
  always_comb begin
    cnt_nx = cnt;
    if (clr)                  cnt_nx = '0;
    else if (inc && cnt != '1) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/chg_setpoints.sv
module chg_setpoints #(
  parameter int VW          = 13,
  parameter int IW          = 10,
  parameter int VTERM_LO_MV = 4100,
  parameter int VTERM_HI_MV = 4200,
  parameter int RECH_PCT    = 97,
  parameter int ITERM_PCT   = 10,
  parameter int ITRK_PCT    = 10
) (
  input  logic          vterm_hi,
  input  logic [IW-1:0] ilim_ma,
  output logic [VW-1:0] vterm_mv,
  output logic [VW-1:0] vrech_mv,
  output logic [IW-1:0] iterm_ma,
  output logic [IW-1:0] itrk_ma
);
  localparam int VPW = VW + 7;
  localparam int IPW = IW + 7;

  logic [VPW-1:0] vprod;
  logic [IPW-1:0] tprod, kprod;

  always_comb begin
    vterm_mv = vterm_hi ? VW'(VTERM_HI_MV) : VW'(VTERM_LO_MV);
    vprod    = VPW'(vterm_mv) * VPW'(RECH_PCT);
    vrech_mv = VW'(vprod / VPW'(100));
    tprod    = IPW'(ilim_ma) * IPW'(ITERM_PCT);
    kprod    = IPW'(ilim_ma) * IPW'(ITRK_PCT);
    iterm_ma = IW'(tprod / IPW'(100));
    itrk_ma  = IW'(kprod / IPW'(100));
  end
endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_cycle_pkg::*;
#(
  parameter int VW            = 13,
  parameter int IW            = 10,
  parameter int RETRY_MS      = 500,
  parameter int TRICKLE_TO_MS = 600000,
  parameter int CHARGE_TO_MS  = 25200000,
  parameter int PRESENT_MV    = 1000,
  parameter int MIN_CHG_MV    = 2100,
  parameter int FAST_MV       = 2900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          vbus_ok,
  input  logic          hdrm_ok,
  input  logic          vterm_hi,
  input  logic [IW-1:0] ilim_ma,
  input  logic          temp_ok,
  input  logic          temp_reduce,
  input  logic          short_det,
  input  logic          self_fault,
  input  logic [VW-1:0] vbat_mv,
  input  logic [IW-1:0] ibat_ma,
  output logic [IW-1:0] ichg_tgt_ma,
  output logic [VW-1:0] vchg_tgt_mv,
  output logic          chg_n,
  output logic          err_n
);
  localparam int MAX_A = (TRICKLE_TO_MS > CHARGE_TO_MS) ? TRICKLE_TO_MS : CHARGE_TO_MS;
  localparam int MAX_T = (RETRY_MS > MAX_A) ? RETRY_MS : MAX_A;
  localparam int TW    = $clog2(MAX_T + 1);

  chg_state_e    state_q, state_nx;
  logic          tmr_clr, tmr_inc;
  logic [TW-1:0] tmr_cnt;
  logic [VW-1:0] vterm_mv, vrech_mv;
  logic [IW-1:0] iterm_ma, itrk_ma;
  logic          hard_err, under_v, chg_phase, chg_on;

  chg_setpoints #(.VW(VW), .IW(IW)) u_setp (
    .vterm_hi (vterm_hi),
    .ilim_ma  (ilim_ma),
    .vterm_mv (vterm_mv),
    .vrech_mv (vrech_mv),
    .iterm_ma (iterm_ma),
    .itrk_ma  (itrk_ma)
  );

  chg_ms_timer #(.CW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .inc   (tmr_inc),
    .cnt   (tmr_cnt)
  );

  assign hard_err  = short_det | self_fault;
  assign under_v   = vbat_mv < VW'(MIN_CHG_MV);
  assign chg_phase = (state_q == ST_TRICKLE) || (state_q == ST_FAST) || (state_q == ST_CV);
  assign chg_on    = chg_phase && hdrm_ok;

  // next-state and timer control
  always_comb begin
    state_nx = state_q;
    tmr_clr  = 1'b0;
    tmr_inc  = 1'b0;
    if (!vbus_ok) begin
      state_nx = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:    state_nx = ST_DETECT;
        ST_DETECT: begin
          if (hard_err) state_nx = ST_FAULT;
          else begin
            tmr_inc = ms_tick;
            if (tmr_cnt == '0 && vbat_mv >= VW'(PRESENT_MV)) state_nx = ST_TRICKLE;
            else if (ms_tick && tmr_cnt == TW'(RETRY_MS - 1)) tmr_clr = 1'b1;
          end
        end
        ST_TRICKLE: begin
          if (hard_err || under_v || tmr_cnt >= TW'(TRICKLE_TO_MS)) state_nx = ST_FAULT;
          else if (hdrm_ok) begin
            tmr_inc = ms_tick;
            if (vbat_mv >= VW'(FAST_MV)) state_nx = ST_FAST;
          end
        end
        ST_FAST: begin
          if (hard_err || under_v || tmr_cnt >= TW'(CHARGE_TO_MS)) state_nx = ST_FAULT;
          else if (hdrm_ok) begin
            tmr_inc = ms_tick;
            if (vbat_mv >= vterm_mv) state_nx = ST_CV;
          end
        end
        ST_CV: begin
          if (hard_err || under_v || tmr_cnt >= TW'(CHARGE_TO_MS)) state_nx = ST_FAULT;
          else if (hdrm_ok) begin
            tmr_inc = ms_tick;
            if (ibat_ma <= iterm_ma) state_nx = ST_DONE;
          end
        end
        ST_DONE: begin
          if (hard_err) state_nx = ST_FAULT;
          else if (vbat_mv < vrech_mv) state_nx = ST_FAST;
        end
        default: state_nx = ST_FAULT;
      endcase
    end
    // phase timer restarts on entry to probe, pre-charge and constant current
    if (state_nx != state_q &&
        (state_nx == ST_DETECT || state_nx == ST_TRICKLE || state_nx == ST_FAST))
      tmr_clr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_nx;
  end

  // setpoints and indicators
  always_comb begin
    ichg_tgt_ma = '0;
    if (chg_on && temp_ok) begin
      case (state_q)
        ST_TRICKLE: ichg_tgt_ma = itrk_ma;
        ST_FAST:    ichg_tgt_ma = temp_reduce ? (ilim_ma >> 1) : ilim_ma;
        default:    ichg_tgt_ma = ilim_ma;
      endcase
    end
    vchg_tgt_mv = (chg_phase || state_q == ST_DONE) ? vterm_mv : '0;
    chg_n       = ~chg_on;
    err_n       = (state_q != ST_FAULT);
  end

  // R9: a fault holds while the supply stays up
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && vbus_ok) |=> (state_q == ST_FAULT));

  // R9: supply loss always returns to idle
  p_vbus_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_ok |=> (state_q == ST_OFF && err_n && ichg_tgt_ma == '0));

  // R4: constant voltage is reached only from constant current
  p_cv_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FAST && state_q != ST_CV) |=> (state_q != ST_CV));

  // R5: completion is reached only from constant voltage
  p_done_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CV && state_q != ST_DONE) |=> (state_q != ST_DONE));

  // R8: fault indicator excludes charging
  p_err_no_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (chg_n && ichg_tgt_ma == '0));

  // R10: no current without headroom
  p_headroom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hdrm_ok |-> (ichg_tgt_ma == '0 && chg_n));

  // R7: pre-charge count never passes its limit
  p_trk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRICKLE) |-> (tmr_cnt <= TW'(TRICKLE_TO_MS)));
endmodule

// File: tb/chg_cycle_ctrl_tb_top.sv
module chg_cycle_ctrl_tb_top;
  localparam int VW = 13;
  localparam int IW = 10;
  localparam int TRK_TO = 40;
  localparam int CHG_TO = 120;
  localparam int RETRY  = 8;

  logic          clk = 1'b0;
  logic          rst_n, ms_tick, vbus_ok, hdrm_ok, vterm_hi, temp_ok, temp_reduce;
  logic          short_det, self_fault;
  logic [IW-1:0] ilim_ma, ibat_ma, ichg_tgt_ma;
  logic [VW-1:0] vbat_mv, vchg_tgt_mv;
  logic          chg_n, err_n;
  int            n_vec = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  chg_cycle_ctrl #(
    .VW(VW), .IW(IW), .RETRY_MS(RETRY), .TRICKLE_TO_MS(TRK_TO), .CHARGE_TO_MS(CHG_TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .vbus_ok(vbus_ok), .hdrm_ok(hdrm_ok),
    .vterm_hi(vterm_hi), .ilim_ma(ilim_ma), .temp_ok(temp_ok), .temp_reduce(temp_reduce),
    .short_det(short_det), .self_fault(self_fault), .vbat_mv(vbat_mv), .ibat_ma(ibat_ma),
    .ichg_tgt_ma(ichg_tgt_ma), .vchg_tgt_mv(vchg_tgt_mv), .chg_n(chg_n), .err_n(err_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_i(input string tag, input int exp, input int maxc);
    for (int n = 0; n < maxc && int'(ichg_tgt_ma) != exp; n++) step(1);
    chk(tag, ichg_tgt_ma, exp);
  endtask

  task automatic new_session(input int lim, input bit sel, input int vb, input int ib);
    vbus_ok = 1'b0;
    step(2);
    ilim_ma = IW'(lim); vterm_hi = sel; vbat_mv = VW'(vb); ibat_ma = IW'(ib);
    hdrm_ok = 1'b1; temp_ok = 1'b1; temp_reduce = 1'b0;
    short_det = 1'b0; self_fault = 1'b0;
    vbus_ok = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ms_tick = 1'b1; vbus_ok = 1'b1; hdrm_ok = 1'b1; vterm_hi = 1'b0;
    ilim_ma = IW'(200); temp_ok = 1'b1; temp_reduce = 1'b0; short_det = 1'b0;
    self_fault = 1'b0; vbat_mv = VW'(3000); ibat_ma = '0;
    step(3);
    chk("R1 itgt", ichg_tgt_ma, 0);
    chk("R1 vtgt", vchg_tgt_mv, 0);
    chk("R1 chg_n", chg_n, 1);
    chk("R1 err_n", err_n, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_detect_timing();
    new_session(200, 1'b0, 0, 0);
    step(3);
    vbat_mv = VW'(2500);
    step(3);
    chk("R2 no probe mid-period", ichg_tgt_ma, 0);
    wait_i("R2 detected at next probe", 20, 10);
  endtask

  task automatic t_detect_level();
    new_session(200, 1'b0, 999, 0);
    step(30);
    chk("R2 999mV absent itgt", ichg_tgt_ma, 0);
    chk("R2 999mV absent err_n", err_n, 1);
    vbat_mv = VW'(1000);
    step(12);
    chk("R2/R8 1000mV detected then undervolt", err_n, 0);
  endtask

  task automatic t_full_cycle(input int lim, input bit sel);
    int vt, vr, itk, half;
    vt = sel ? 4200 : 4100;
    vr = (vt * 97) / 100;
    itk = (lim * 10) / 100;
    half = lim / 2;
    new_session(lim, sel, 2500, lim);
    wait_i("R3 trickle current", itk, 12);
    chk("R3 chg_n low", chg_n, 0);
    chk("R4 vterm shown", vchg_tgt_mv, vt);
    vbat_mv = VW'(2899);
    step(3);
    chk("R3 stays below 2900", ichg_tgt_ma, itk);
    vbat_mv = VW'(2900);
    step(1);
    chk("R3 fast at 2900", ichg_tgt_ma, lim);
    temp_reduce = 1'b1;
    step(1);
    chk("R11 reduced", ichg_tgt_ma, half);
    temp_ok = 1'b0;
    step(1);
    chk("R11 temp block itgt", ichg_tgt_ma, 0);
    chk("R11 temp block chg_n", chg_n, 0);
    temp_ok = 1'b1;
    vbat_mv = VW'(vt - 1);
    step(2);
    chk("R4 below vterm still fast", ichg_tgt_ma, half);
    vbat_mv = VW'(vt);
    step(1);
    chk("R4 cv at vterm", ichg_tgt_ma, lim);
    ibat_ma = IW'(itk + 1);
    step(3);
    chk("R5 above iterm stays cv", ichg_tgt_ma, lim);
    ibat_ma = IW'(itk);
    step(1);
    chk("R5 done itgt", ichg_tgt_ma, 0);
    chk("R5 done chg_n", chg_n, 1);
    chk("R5 done vtgt", vchg_tgt_mv, vt);
    vbat_mv = VW'(vr);
    step(3);
    chk("R6 at threshold stays done", ichg_tgt_ma, 0);
    vbat_mv = VW'(vr - 1);
    step(1);
    chk("R6 recharge to fast", ichg_tgt_ma, half);
    chk("R6 recharge chg_n", chg_n, 0);
  endtask

  task automatic t_trickle_pause_timeout();
    new_session(200, 1'b0, 2500, 0);
    wait_i("R7 trickle start", 20, 12);
    step(20);
    hdrm_ok = 1'b0;
    step(30);
    chk("R10 no headroom itgt", ichg_tgt_ma, 0);
    chk("R10 no headroom chg_n", chg_n, 1);
    chk("R10 no headroom no fault", err_n, 1);
    hdrm_ok = 1'b1;
    step(15);
    chk("R10 resumed, timer paused", ichg_tgt_ma, 20);
    step(8);
    chk("R7 trickle timeout", err_n, 0);
  endtask

  task automatic t_trickle_exact();
    new_session(200, 1'b0, 2500, 0);
    wait_i("R7 trickle start", 20, 12);
    step(TRK_TO - 2);
    chk("R7 before trickle limit", err_n, 1);
    step(4);
    chk("R7 after trickle limit", err_n, 0);
  endtask

  task automatic t_charge_timeout();
    new_session(200, 1'b0, 2500, 200);
    wait_i("R7 trickle start", 20, 12);
    temp_reduce = 1'b1;
    vbat_mv = VW'(2900);
    wait_i("R7 fast start", 100, 3);
    step(60);
    vbat_mv = VW'(4100);
    step(55);
    chk("R7 cv before combined limit", ichg_tgt_ma, 200);
    chk("R7 no fault yet", err_n, 1);
    step(8);
    chk("R7 combined timeout", err_n, 0);
  endtask

  task automatic t_errors();
    new_session(200, 1'b0, 2500, 200);
    wait_i("R8 trickle start", 20, 12);
    vbat_mv = VW'(2099);
    step(1);
    chk("R8 undervolt err_n", err_n, 0);
    chk("R8 undervolt chg_n", chg_n, 1);
    chk("R8 undervolt itgt", ichg_tgt_ma, 0);
    vbat_mv = VW'(3000);
    step(5);
    chk("R9 latched", err_n, 0);
    vbus_ok = 1'b0;
    step(1);
    chk("R9 cleared on supply loss", err_n, 1);
    vbus_ok = 1'b1;
    wait_i("R9 new cycle after reconnect", 200, 30);
    short_det = 1'b1;
    step(1);
    short_det = 1'b0;
    step(3);
    chk("R8 short latched", err_n, 0);
    new_session(200, 1'b0, 4100, 10);
    step(20);
    chk("R5 done via cv itgt", ichg_tgt_ma, 0);
    chk("R5 done via cv vtgt", vchg_tgt_mv, 4100);
    self_fault = 1'b1;
    step(1);
    chk("R8 internal fault", err_n, 0);
    self_fault = 1'b0;
  endtask

  initial begin
    t_reset();
    t_detect_timing();
    t_detect_level();
    t_full_cycle(200, 1'b0);
    t_full_cycle(255, 1'b1);
    t_trickle_pause_timeout();
    t_trickle_exact();
    t_charge_timeout();
    t_errors();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule